// File: doc/BRIEF.md
# Inter-Packet Gap Deferral Timer

This block decides when a half-duplex Ethernet MAC may begin a transmission. It counts idle time on the medium in nibble units, one count per `nib_tick` pulse. When the selected gap has run out, it raises `may_tx`. The gap starts once the medium is quiet, meaning both the received carrier and the local transmitter are inactive. Three programmable gaps are available: the normal gap between data frames, the gap between jam bursts, and the gap from a jam burst to the next data frame. `gap_mode` chooses one of them each time a gap starts.

A programmable blinder window gives stations fair access to the medium. Carrier that appears during the first part of the gap, while fewer than the blinder number of nibbles have been counted, sends the timer back to wait for a quiet medium. The gap then starts over from zero. Carrier that appears after the window has passed is ignored, and the gap runs to completion. The four fields are captured only while `enable` is low, because they may only be changed while the port is disabled.

The control is a five-state machine:
- OFF: disabled.
- HOLD: the medium is busy. The counter is held at zero and the gap selection is captured.
- BLIND: counting inside the blinder window.
- OPEN: counting after the window.
- GO: the gap has elapsed and `may_tx` is high.

Transitions:
- OFF→HOLD when enabled.
- HOLD→BLIND when the medium is quiet.
- BLIND→HOLD on carrier or local transmit.
- BLIND→OPEN on the tick that reaches the blinder count.
- BLIND→GO or OPEN→GO on the tick that reaches the gap.
- OPEN→HOLD on local transmit.
- GO→HOLD on local transmit or on a rising carrier.
- Any state→OFF when `enable` is low.

Top module: `ipg_defer_timer`

## Requirements
- R1: `may_tx` is low during reset. It is low in every cycle that follows a cycle in which `enable` was low.
- R2: The gap begins in the cycle after the first clock edge at which `enable` is high and both `carrier` and `tx_active` are low. This also applies after a local transmission ends. A tick in that first cycle is not counted.
- R3: The gap length in nibbles equals the field value, with one nibble being 4 bit-times. With a tick every cycle, `may_tx` rises 2 + G cycles after `enable` rises on a quiet medium, where G is the effective gap.
- R4: `gap_mode` encodings are 0 = data gap, 1 = jam gap, 2 = jam-to-data gap, and 3 = data gap. The mode is taken from its value at the moment the gap starts.
- R5: Field values below their legal minimum are raised to that minimum. The minimum is 3 for the data gap, 1 for the jam gap and the jam-to-data gap, and 3 for the blinder.
- R6: Carrier seen at a clock edge while the count is below the blinder value abandons the gap. Counting restarts from zero once the medium is quiet again. This applies up to and including a count of blinder−1.
- R7: Carrier seen at an edge while the count is at or above the blinder value has no effect. This holds even when carrier stays high through the end of the gap, and `may_tx` then stays high while carrier remains steady.
- R8: While `may_tx` is high, either `tx_active` or a rising edge of `carrier` drops `may_tx` in the next cycle. The timer then waits for a quiet medium.
- R9: The four fields are captured only at edges where `enable` is low. Changes made while enabled have no effect until the next disabled edge.
- R10: The count advances only at edges where `nib_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; fields captured while low |
| nib_tick | input | 1 | One pulse per nibble time |
| carrier | input | 1 | Receive carrier sense |
| tx_active | input | 1 | Local transmitter busy |
| gap_mode | input | 2 | Gap selection (see R4) |
| data_gap | input | FIELD_W | Data-to-data gap, nibbles |
| jam_gap | input | FIELD_W | Jam-to-jam gap, nibbles |
| jam2data_gap | input | FIELD_W | Jam-to-data gap, nibbles |
| blind_nib | input | FIELD_W | Blinder window, nibbles |
| may_tx | output | 1 | Gap elapsed, transmission allowed |

## Verification
The hardest situations to produce are the two sides of the blinder boundary: carrier arriving exactly at count blinder−1, where the gap must restart, and exactly at count blinder, where it must not. The bench reaches both by enabling the timer on a quiet medium with one tick per cycle, so the count is a known function of the cycle number. Carrier is then raised on the precise cycle that lands each count. A second hard case is carrier that rises late and is still high when the gap ends. The bench holds carrier across the end of the gap, checks that `may_tx` stays up, and only then produces a fresh rising edge.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_BLIND,
        ST_OPEN,
        ST_GO
    } defer_st_e;

    localparam logic [1:0] MODE_DATA     = 2'd0;
    localparam logic [1:0] MODE_JAM      = 2'd1;
    localparam logic [1:0] MODE_JAM2DATA = 2'd2;

    localparam int CF_DATA  = 0;
    localparam int CF_JAM   = 1;
    localparam int CF_J2D   = 2;
    localparam int CF_BLIND = 3;
    localparam int CF_COUNT = 4;

endpackage

// File: rtl/ipg_cfg_latch.sv
module ipg_cfg_latch
    import ipg_defer_pkg::*;
#(
    parameter int FIELD_W   = 5,
    parameter int DATA_MIN  = 3,
    parameter int JAM_MIN   = 1,
    parameter int BLIND_MIN = 3,
    parameter int BLIND_RST = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              enable,
    input  logic [CF_COUNT-1:0][FIELD_W-1:0]  raw_i,
    output logic [CF_COUNT-1:0][FIELD_W-1:0]  eff_o
);

    for (genvar f = 0; f < CF_COUNT; f++) begin : g_field
        localparam int LO = (f == CF_BLIND) ? BLIND_MIN :
                            (f == CF_DATA)  ? DATA_MIN  : JAM_MIN;
        localparam int RV = (f == CF_BLIND) ? BLIND_RST : LO;

        logic [FIELD_W-1:0] clamped;
        logic [FIELD_W-1:0] held_q;

        assign clamped = (raw_i[f] < FIELD_W'(LO)) ? FIELD_W'(LO) : raw_i[f];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= FIELD_W'(RV);
            end else if (!enable) begin
                held_q <= clamped;
            end
        end

        assign eff_o[f] = held_q;
    end

endmodule

// File: rtl/ipg_nib_counter.sv
module ipg_nib_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear) begin
            cnt_o <= '0;
        end else if (step) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ipg_defer_fsm.sv
module ipg_defer_fsm
    import ipg_defer_pkg::*;
#(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               nib_tick,
    input  logic               carrier,
    input  logic               tx_active,
    input  logic [1:0]         gap_mode,
    input  logic [FIELD_W-1:0] eff_data,
    input  logic [FIELD_W-1:0] eff_jam,
    input  logic [FIELD_W-1:0] eff_j2d,
    input  logic [FIELD_W-1:0] eff_blind,
    input  logic [FIELD_W-1:0] cnt,
    output logic               cnt_clear,
    output logic               cnt_step,
    output logic               may_tx
);

    localparam int NXT_W = FIELD_W + 1;

    defer_st_e          state, nstate;
    logic [FIELD_W-1:0] gap_sel;
    logic [FIELD_W-1:0] mode_gap;
    logic               carrier_q;
    logic [NXT_W-1:0]   nxt;
    logic               reach_gap;
    logic               reach_blind;
    logic               medium_busy;
    logic               carrier_rise;

    always_comb begin
        unique case (gap_mode)
            MODE_JAM:      mode_gap = eff_jam;
            MODE_JAM2DATA: mode_gap = eff_j2d;
            default:       mode_gap = eff_data;
        endcase
    end

    assign nxt          = NXT_W'(cnt) + NXT_W'(1);
    assign reach_gap    = nib_tick && (nxt == NXT_W'(gap_sel));
    assign reach_blind  = nib_tick && (nxt == NXT_W'(eff_blind));
    assign medium_busy  = carrier || tx_active;
    assign carrier_rise = carrier && !carrier_q;

    // next-state selection
    always_comb begin
        nstate = state;
        if (!enable) begin
            nstate = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nstate = ST_HOLD;
                ST_HOLD:  if (!medium_busy) nstate = ST_BLIND;
                ST_BLIND: begin
                    if (medium_busy)      nstate = ST_HOLD;
                    else if (reach_gap)   nstate = ST_GO;
                    else if (reach_blind) nstate = ST_OPEN;
                end
                ST_OPEN: begin
                    if (tx_active)        nstate = ST_HOLD;
                    else if (reach_gap)   nstate = ST_GO;
                end
                ST_GO: begin
                    if (tx_active || carrier_rise) nstate = ST_HOLD;
                end
                default:  nstate = ST_OFF;
            endcase
        end
    end

    // state register and gap capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            gap_sel   <= '0;
            carrier_q <= 1'b0;
        end else begin
            state     <= nstate;
            carrier_q <= carrier;
            if (state == ST_HOLD) begin
                gap_sel <= mode_gap;
            end
        end
    end

    // outputs
    always_comb begin
        may_tx    = (state == ST_GO);
        cnt_clear = (state == ST_HOLD) || (state == ST_OFF);
        cnt_step  = nib_tick && ((state == ST_BLIND) || (state == ST_OPEN));
    end

endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer
    import ipg_defer_pkg::*;
#(
    parameter int FIELD_W   = 5,
    parameter int DATA_MIN  = 3,
    parameter int JAM_MIN   = 1,
    parameter int BLIND_MIN = 3,
    parameter int BLIND_RST = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               nib_tick,
    input  logic               carrier,
    input  logic               tx_active,
    input  logic [1:0]         gap_mode,
    input  logic [FIELD_W-1:0] data_gap,
    input  logic [FIELD_W-1:0] jam_gap,
    input  logic [FIELD_W-1:0] jam2data_gap,
    input  logic [FIELD_W-1:0] blind_nib,
    output logic               may_tx
);

    logic [CF_COUNT-1:0][FIELD_W-1:0] raw_f;
    logic [CF_COUNT-1:0][FIELD_W-1:0] eff_f;
    logic [FIELD_W-1:0]               cnt;
    logic                             cnt_clear;
    logic                             cnt_step;

    assign raw_f[CF_DATA]  = data_gap;
    assign raw_f[CF_JAM]   = jam_gap;
    assign raw_f[CF_J2D]   = jam2data_gap;
    assign raw_f[CF_BLIND] = blind_nib;

    ipg_cfg_latch #(
        .FIELD_W  (FIELD_W),
        .DATA_MIN (DATA_MIN),
        .JAM_MIN  (JAM_MIN),
        .BLIND_MIN(BLIND_MIN),
        .BLIND_RST(BLIND_RST)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .raw_i (raw_f),
        .eff_o (eff_f)
    );

    ipg_nib_counter #(
        .CNT_W(FIELD_W)
    ) cnt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .step (cnt_step),
        .cnt_o(cnt)
    );

    ipg_defer_fsm #(
        .FIELD_W(FIELD_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .nib_tick (nib_tick),
        .carrier  (carrier),
        .tx_active(tx_active),
        .gap_mode (gap_mode),
        .eff_data (eff_f[CF_DATA]),
        .eff_jam  (eff_f[CF_JAM]),
        .eff_j2d  (eff_f[CF_J2D]),
        .eff_blind(eff_f[CF_BLIND]),
        .cnt      (cnt),
        .cnt_clear(cnt_clear),
        .cnt_step (cnt_step),
        .may_tx   (may_tx)
    );

endmodule

// File: rtl/ipg_defer_sva.sv
module ipg_defer_sva (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic nib_tick,
    input logic carrier,
    input logic tx_active,
    input logic may_tx
);

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !may_tx); // R1

    AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(may_tx) |-> $past(enable)); // R1

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(may_tx) |-> $past(nib_tick)); // R10

    AST_RISE_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(may_tx) |-> !$past(tx_active)); // R2

    AST_TX_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (may_tx && tx_active && enable) |=> !may_tx); // R8

    AST_CAR_EDGE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (may_tx && enable && $rose(carrier)) |=> !may_tx); // R8

endmodule

bind ipg_defer_timer ipg_defer_sva sva_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .nib_tick (nib_tick),
    .carrier  (carrier),
    .tx_active(tx_active),
    .may_tx   (may_tx)
);

// File: tb/ipg_defer_timer_tb_top.sv
`timescale 1ns/1ps
module ipg_defer_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       nib_tick = 1'b1;
    logic       carrier = 1'b0;
    logic       tx_active = 1'b0;
    logic [1:0] gap_mode = 2'd0;
    logic [4:0] data_gap = 5'd6;
    logic [4:0] jam_gap = 5'd2;
    logic [4:0] jam2data_gap = 5'd4;
    logic [4:0] blind_nib = 5'd3;
    logic       may_tx;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";
    int    tick_period = 1;
    int    tick_ctr = 0;

    // behavioural reference state
    int m_phase = 0;     // 0 off, 1 waiting for quiet, 2 counting, 3 allowed
    int m_cnt = 0;
    int m_gap = 0;
    int c_data = 3, c_jam = 1, c_j2d = 1, c_blind = 16;
    bit m_prev_car = 1'b0;

    always #4 clk = ~clk;

    ipg_defer_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .nib_tick    (nib_tick),
        .carrier     (carrier),
        .tx_active   (tx_active),
        .gap_mode    (gap_mode),
        .data_gap    (data_gap),
        .jam_gap     (jam_gap),
        .jam2data_gap(jam2data_gap),
        .blind_nib   (blind_nib),
        .may_tx      (may_tx)
    );

    function automatic int lift(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

    task automatic check_int(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_gap = 0; m_prev_car = 1'b0;
            c_data = 3; c_jam = 1; c_j2d = 1; c_blind = 16;
        end else begin
            if (!enable) begin
                c_data  = lift(int'(data_gap), 3);
                c_jam   = lift(int'(jam_gap), 1);
                c_j2d   = lift(int'(jam2data_gap), 1);
                c_blind = lift(int'(blind_nib), 3);
                m_phase = 0;
            end else if (m_phase == 0) begin
                m_phase = 1;
            end else if (m_phase == 1) begin
                if (!carrier && !tx_active) begin
                    m_phase = 2;
                    m_cnt = 0;
                    m_gap = (gap_mode == 2'd1) ? c_jam :
                            (gap_mode == 2'd2) ? c_j2d : c_data;
                end
            end else if (m_phase == 2) begin
                if (tx_active || (carrier && m_cnt < c_blind)) begin
                    m_phase = 1;
                end else if (nib_tick) begin
                    m_cnt++;
                    if (m_cnt == m_gap) m_phase = 3;
                end
            end else begin
                if (tx_active || (carrier && !m_prev_car)) m_phase = 1;
            end
            m_prev_car = carrier;
        end
    end

    always @(negedge clk) begin
        tick_ctr++;
        nib_tick = ((tick_ctr % tick_period) == 0);
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check_int({cur_req, " per-cycle may_tx"}, int'(may_tx), (m_phase == 3) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic go_off();
        enable = 1'b0; carrier = 1'b0; tx_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(int d, int j, int jd, int b, int mode);
        enable = 1'b0;
        data_gap = 5'(d); jam_gap = 5'(j); jam2data_gap = 5'(jd);
        blind_nib = 5'(b); gap_mode = 2'(mode);
        @(negedge clk);
    endtask

    // raise enable and count cycles until may_tx; optional carrier pulse and field change
    task automatic run_gap(int car_at, int car_len, int change_at, output int cycles);
        int n = 0;
        cycles = -1;
        enable = 1'b1;
        while (n < 300) begin
            @(negedge clk);
            n++;
            if (may_tx) begin
                cycles = n;
                break;
            end
            if (n == car_at) carrier = 1'b1;
            if (n == car_at + car_len) carrier = 1'b0;
            if (n == change_at) data_gap = 5'd20;
        end
    endtask

    task automatic wait_go(output int cycles);
        int n = 0;
        cycles = -1;
        while (n < 300) begin
            @(negedge clk);
            n++;
            if (may_tx) begin
                cycles = n;
                break;
            end
        end
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        check_int("R1 reset may_tx", int'(may_tx), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R1 disabled may_tx", int'(may_tx), 0);

        cur_req = "R3";
        setup(6, 2, 4, 3, 0);
        run_gap(0, 0, 0, c);
        check_int("R3 data gap 6 latency", c, 8);

        cur_req = "R4";
        go_off(); setup(6, 2, 4, 3, 1);
        run_gap(0, 0, 0, c);
        check_int("R4 jam gap latency", c, 4);
        go_off(); setup(6, 2, 4, 3, 2);
        run_gap(0, 0, 0, c);
        check_int("R4 jam-to-data latency", c, 6);
        go_off(); setup(6, 2, 4, 3, 3);
        run_gap(0, 0, 0, c);
        check_int("R4 mode 3 uses data gap", c, 8);

        cur_req = "R5";
        go_off(); setup(1, 0, 0, 3, 0);
        run_gap(0, 0, 0, c);
        check_int("R5 data gap raised to 3", c, 5);
        go_off(); setup(1, 0, 0, 3, 1);
        run_gap(0, 0, 0, c);
        check_int("R5 jam gap raised to 1", c, 3);
        go_off(); setup(1, 0, 0, 3, 2);
        run_gap(0, 0, 0, c);
        check_int("R5 jam-to-data raised to 1", c, 3);
        go_off(); setup(10, 2, 4, 0, 0);
        run_gap(4, 1, 0, c);
        check_int("R5 blinder raised to 3 restarts", c, 16);

        cur_req = "R6";
        go_off(); setup(10, 2, 4, 6, 0);
        run_gap(4, 1, 0, c);
        check_int("R6 early carrier restarts", c, 16);
        go_off(); setup(10, 2, 4, 6, 0);
        run_gap(7, 1, 0, c);
        check_int("R6 carrier at blinder-1 restarts", c, 19);

        cur_req = "R7";
        go_off(); setup(10, 2, 4, 6, 0);
        run_gap(8, 1, 0, c);
        check_int("R7 carrier at blinder ignored", c, 12);
        go_off(); setup(10, 2, 4, 6, 0);
        run_gap(10, 2, 0, c);
        check_int("R7 late carrier ignored", c, 12);
        go_off(); setup(10, 2, 4, 6, 0);
        run_gap(9, 100, 0, c);
        check_int("R7 held carrier still reaches go", c, 12);
        repeat (3) @(negedge clk);
        check_int("R7 steady carrier keeps may_tx", int'(may_tx), 1);

        cur_req = "R8";
        carrier = 1'b0;
        @(negedge clk);
        check_int("R8 carrier fall keeps may_tx", int'(may_tx), 1);
        carrier = 1'b1;
        @(negedge clk);
        check_int("R8 carrier rise drops may_tx", int'(may_tx), 0);
        carrier = 1'b0;
        cur_req = "R2";
        wait_go(c);
        check_int("R2 gap after carrier drop", c, 11);
        cur_req = "R8";
        tx_active = 1'b1;
        @(negedge clk);
        check_int("R8 tx_active drops may_tx", int'(may_tx), 0);
        @(negedge clk);
        tx_active = 1'b0;
        cur_req = "R2";
        wait_go(c);
        check_int("R2 gap after local transmit", c, 11);

        cur_req = "R9";
        go_off(); setup(10, 2, 4, 6, 0);
        run_gap(0, 0, 1, c);
        check_int("R9 change while enabled ignored", c, 12);
        go_off();
        run_gap(0, 0, 0, c);
        check_int("R9 new value taken after disable", c, 22);

        cur_req = "R10";
        tick_period = 3;
        go_off(); setup(4, 2, 4, 3, 0);
        run_gap(0, 0, 0, c);
        check_int("R10 sparse ticks lengthen gap", (c >= 12) ? 1 : 0, 1);
        tick_period = 1;

        cur_req = "R1";
        go_off();
        @(negedge clk);
        check_int("R1 disable clears may_tx", int'(may_tx), 0);
        repeat (2) @(negedge clk);
        cmp_on = 1'b0;
        summary();
    end

endmodule